// File: doc/BRIEF.md
# DMA Control Register Bank with Interrupt Aggregation

This block is the software-visible register bank of a multi-channel DMA controller. A 32-bit register bus reaches a small global group (a controller CSR, two interrupt masks and two interrupt source words) and, above a fixed channel base, one 32-byte window per channel. Each window holds eight words: a channel CSR, a size word, source and destination addresses, their wrap masks, a descriptor pointer and a software pointer. All of them are driven out to the channel engines. The engines report back with done, error and chunk-done pulses and a busy level.

Reads have side effects. A read of interrupt source A hands back its value, clears it and drops the interrupt line. A read of a channel CSR clears that channel's sticky status bits. Channel CSR writes pass through a writable-bit mask, and they raise one-cycle start or cancel strobes for that channel.

Top module: `dma_regbank`

Byte addresses, with the two low bits ignored:

| Area | Offsets |
|---|---|
| Global | 0x00 controller CSR, 0x04 mask A, 0x08 mask B, 0x0C source A, 0x10 source B; 0x14 to 0x1F undefined |
| Channel n | base 0x20 + 0x20·n |
| Within a window | +0x00 CSR, +0x04 SZ, +0x08 A0, +0x0C AM0, +0x10 A1, +0x14 AM1, +0x18 DESC, +0x1C SWPTR |

Channel CSR bits:

| Bit | Name | Owner | Notes |
|---|---|---|---|
| 0 | EN | software | |
| 1 | BUSY | hardware | mirror of busy input |
| 2 | DONE | hardware | |
| 3 | ERR | hardware | cleared by CSR read |
| 4 to 9 | transfer options | software | |
| 10 | IE_ERR | software | error interrupt enable |
| 11 | IE_DONE | software | done interrupt enable |
| 12 | IE_CHUNK | software | chunk-done interrupt enable |
| 13 | INT_ERR | hardware | sticky |
| 14 | INT_DONE | hardware | sticky |
| 15 | INT_CHUNK | hardware | sticky |

## Requirements
- R1: After reset, every register reads zero and the interrupt line is low. The one exception is each channel's AM0 and AM1, which read 0xFFFFFFFC.
- R2: A read accepted in cycle t returns its data, with bus_rvalid high, in cycle t+1. Channel n's window starts at 0x20+0x20·n, and each window register written reads back and appears on its channel output slice.
- R3: A channel CSR write changes only the bits in mask 0x00001FF1. The hardware bits (BUSY, DONE, ERR, bits 13 to 15) keep their values.
- R4: If a CSR write takes EN (bit 0) from 0 to 1, the channel's start strobe pulses in the next cycle. A CSR write with EN=0 pulses the cancel strobe instead. A write with EN=1 while EN is already 1 pulses neither.
- R5: A done pulse sets DONE and clears EN. An error pulse sets ERR and clears EN. BUSY follows the busy input with a one-cycle delay.
- R6: A channel raises an interrupt when a done, error or chunk pulse arrives with IE_DONE, IE_ERR or IE_CHUNK set and the channel's bit in mask A set. The matching INT bit (14, 13, 15) is then set, source A is overwritten with the one-hot channel bit, and irq_o goes high. If several channels raise in one cycle, the lowest index wins.
- R7: A pulse whose channel bit in mask A is clear sets no INT bit, leaves source A unchanged and leaves irq_o unchanged.
- R8: A read of source A returns the stored value and then clears it to zero. If the value was nonzero, irq_o drops in the next cycle.
- R9: A channel CSR read returns the current value and then clears bits 3, 13, 14 and 15 (mask 0x0000E008). DONE is kept.
- R10: When an interrupt or status pulse lands in the same cycle as the read that would clear it, the read returns the old value and the new event survives. This holds for source A, irq_o and the channel CSR bits.
- R11: The global CSR always reads zero, and writing it (including its pause bit) has no effect. Undefined global offsets read zero and ignore writes. Mask A, mask B and source B read back what was written.
- R12: Addresses at or above the end of the last channel window read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_valid | input | 1 | register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| bus_rvalid | output | 1 | read data valid |
| ch_csr_o | output | NCH*32 | channel CSRs, channel n at [32n+:32] |
| ch_sz_o | output | NCH*32 | size words |
| ch_a0_o | output | NCH*32 | source addresses |
| ch_am0_o | output | NCH*32 | source wrap masks |
| ch_a1_o | output | NCH*32 | destination addresses |
| ch_am1_o | output | NCH*32 | destination wrap masks |
| ch_desc_o | output | NCH*32 | descriptor pointers |
| ch_swptr_o | output | NCH*32 | software pointers |
| ch_start_o | output | NCH | start strobes |
| ch_cancel_o | output | NCH | cancel strobes |
| ch_done_i | input | NCH | transfer done pulses |
| ch_err_i | input | NCH | error pulses |
| ch_chunk_i | input | NCH | chunk done pulses |
| ch_busy_i | input | NCH | channel busy levels |
| irq_o | output | 1 | interrupt line |

## Verification
Two functions can meet in one cycle: a read-to-clear and an engine event that sets the bits being cleared. The bench provokes this by driving an error pulse on a channel in the very cycle it reads source A, and again in the cycle it reads that channel's CSR. In each case it judges that the read returned the pre-event value, and that the next read still shows the new source bit, the INT_ERR and ERR bits, and a high interrupt line. A second collision, two channels raising together, is judged by the one-hot value left in source A.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int          DW        = 32;
  localparam int          WIN_BYTES = 32;
  localparam logic [31:0] CSR_WMASK = 32'h0000_1FF1;
  localparam logic [31:0] CSR_RCLR  = 32'h0000_E008;
  localparam logic [31:0] AM_RST    = 32'hFFFF_FFFC;

  localparam int B_EN    = 0;
  localparam int B_BUSY  = 1;
  localparam int B_DONE  = 2;
  localparam int B_ERR   = 3;
  localparam int B_IEERR = 10;
  localparam int B_IEDON = 11;
  localparam int B_IECHK = 12;
  localparam int B_IERR  = 13;
  localparam int B_IDON  = 14;
  localparam int B_ICHK  = 15;

  typedef enum logic [2:0] {
    W_CSR, W_SZ, W_A0, W_AM0, W_A1, W_AM1, W_DESC, W_SWPTR
  } win_reg_e;

  typedef enum logic [2:0] {
    G_CSR, G_MSKA, G_MSKB, G_SRCA, G_SRCB, G_NONE
  } glob_e;

  function automatic logic [31:0] csr_merge(input logic [31:0] cur, input logic [31:0] wd);
    return (cur & ~CSR_WMASK) | (wd & CSR_WMASK);
  endfunction

  function automatic logic [31:0] csr_rclr(input logic [31:0] cur);
    return cur & ~CSR_RCLR;
  endfunction
endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
  import dmarb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NCH     = 4,
  parameter int CH_BASE = 32,
  localparam int CIW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output glob_e             gsel,
  output logic              ch_hit,
  output logic [CIW-1:0]    ch_idx,
  output win_reg_e          wreg,
  output logic [NCH-1:0]    wr_ch,
  output logic [NCH-1:0]    rd_csr,
  output logic              rd_srca,
  output logic              gwr,
  output logic              rd_null
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] NCH_A  = ADDR_W'(NCH);

  logic              in_ch;
  logic [ADDR_W-1:0] rel, idx_full, word;
  logic [2:0]        rsel;

  assign in_ch    = (addr >= BASE_A);
  assign rel      = addr - BASE_A;
  assign idx_full = ADDR_W'(rel / WIN_BYTES);
  assign rsel     = 3'((rel % WIN_BYTES) >> 2);
  assign wreg     = win_reg_e'(rsel);
  assign ch_hit   = in_ch && (idx_full < NCH_A);
  assign ch_idx   = CIW'(idx_full);
  assign word     = addr >> 2;

  always_comb begin
    gsel = G_NONE;
    if (!in_ch) begin
      case (word)
        ADDR_W'(0): gsel = G_CSR;
        ADDR_W'(1): gsel = G_MSKA;
        ADDR_W'(2): gsel = G_MSKB;
        ADDR_W'(3): gsel = G_SRCA;
        ADDR_W'(4): gsel = G_SRCB;
        default:    gsel = G_NONE;
      endcase
    end
  end

  always_comb begin
    wr_ch  = '0;
    rd_csr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (valid && ch_hit && ch_idx == CIW'(i)) begin
        wr_ch[i]  = write;
        rd_csr[i] = !write && (wreg == W_CSR);
      end
    end
  end

  assign rd_srca = valid && !write && (gsel == G_SRCA);
  assign gwr     = valid && write && !in_ch;
  assign rd_null = valid && !write &&
                   ((!in_ch && (gsel == G_NONE || gsel == G_CSR)) || (in_ch && !ch_hit));
endmodule

// File: rtl/dmarb_channel.sv
module dmarb_channel
  import dmarb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  win_reg_e    wr_reg,
  input  logic [31:0] wdata,
  input  logic        rd_csr,
  input  logic        ev_done,
  input  logic        ev_err,
  input  logic        ev_chunk,
  input  logic        busy_i,
  input  logic        mask_bit,
  output logic [31:0] csr,
  output logic [31:0] sz,
  output logic [31:0] a0,
  output logic [31:0] am0,
  output logic [31:0] a1,
  output logic [31:0] am1,
  output logic [31:0] desc,
  output logic [31:0] swptr,
  output logic        start_o,
  output logic        cancel_o,
  output logic        raise_o
);
  logic        wr_csr, rs_done, rs_err, rs_chk;
  logic [31:0] csr_nx;

  assign wr_csr  = wr_en && (wr_reg == W_CSR);
  assign rs_done = mask_bit && ev_done  && csr[B_IEDON];
  assign rs_err  = mask_bit && ev_err   && csr[B_IEERR];
  assign rs_chk  = mask_bit && ev_chunk && csr[B_IECHK];
  assign raise_o = rs_done || rs_err || rs_chk;

  always_comb begin
    csr_nx = csr;
    if (rd_csr) csr_nx = csr_rclr(csr_nx);
    if (wr_csr) csr_nx = csr_merge(csr_nx, wdata);
    csr_nx[B_BUSY] = busy_i;
    if (ev_done) begin csr_nx[B_EN] = 1'b0; csr_nx[B_DONE] = 1'b1; end
    if (ev_err)  begin csr_nx[B_EN] = 1'b0; csr_nx[B_ERR]  = 1'b1; end
    if (rs_done) csr_nx[B_IDON] = 1'b1;
    if (rs_err)  csr_nx[B_IERR] = 1'b1;
    if (rs_chk)  csr_nx[B_ICHK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr <= '0; sz <= '0; a0 <= '0; am0 <= AM_RST;
      a1 <= '0; am1 <= AM_RST; desc <= '0; swptr <= '0;
      start_o <= 1'b0; cancel_o <= 1'b0;
    end else begin
      csr      <= csr_nx;
      start_o  <= wr_csr && !csr[B_EN] && wdata[B_EN];
      cancel_o <= wr_csr && !wdata[B_EN];
      if (wr_en) begin
        case (wr_reg)
          W_SZ:    sz    <= wdata;
          W_A0:    a0    <= wdata;
          W_AM0:   am0   <= wdata;
          W_A1:    a1    <= wdata;
          W_AM1:   am1   <= wdata;
          W_DESC:  desc  <= wdata;
          W_SWPTR: swptr <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmarb_irq.sv
module dmarb_irq
  import dmarb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raise,
  input  logic           gwr,
  input  glob_e          gsel,
  input  logic [31:0]    wdata,
  input  logic           rd_srca,
  output logic [31:0]    mska,
  output logic [31:0]    mskb,
  output logic [31:0]    srca,
  output logic [31:0]    srcb,
  output logic           irq
);
  logic [31:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (raise[i]) pick = 32'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mska <= '0; mskb <= '0; srca <= '0; srcb <= '0; irq <= 1'b0;
    end else begin
      if (gwr && gsel == G_MSKA) mska <= wdata;
      if (gwr && gsel == G_MSKB) mskb <= wdata;
      if (gwr && gsel == G_SRCB) srcb <= wdata;
      if (|raise)                      srca <= pick;
      else if (rd_srca)                srca <= '0;
      else if (gwr && gsel == G_SRCA)  srca <= wdata;
      if (|raise)                      irq <= 1'b1;
      else if (rd_srca && srca != '0)  irq <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dmarb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NCH     = 4,
  parameter int CH_BASE = 32,
  localparam int CIW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int VW     = NCH * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [VW-1:0]     ch_csr_o,
  output logic [VW-1:0]     ch_sz_o,
  output logic [VW-1:0]     ch_a0_o,
  output logic [VW-1:0]     ch_am0_o,
  output logic [VW-1:0]     ch_a1_o,
  output logic [VW-1:0]     ch_am1_o,
  output logic [VW-1:0]     ch_desc_o,
  output logic [VW-1:0]     ch_swptr_o,
  output logic [NCH-1:0]    ch_start_o,
  output logic [NCH-1:0]    ch_cancel_o,
  input  logic [NCH-1:0]    ch_done_i,
  input  logic [NCH-1:0]    ch_err_i,
  input  logic [NCH-1:0]    ch_chunk_i,
  input  logic [NCH-1:0]    ch_busy_i,
  output logic              irq_o
);
  glob_e          gsel;
  win_reg_e       wreg;
  logic           ch_hit, rd_srca_w, gwr, rd_null_w;
  logic [CIW-1:0] ch_idx;
  logic [NCH-1:0] wr_ch, rd_csr_w, raise_w, wr_csr_w, ev_any_w;
  logic [31:0]    mska, mskb, srca, srcb, rd_mux;
  logic [31:0]    csr_a [NCH];
  logic [31:0]    sz_a [NCH];
  logic [31:0]    a0_a [NCH];
  logic [31:0]    am0_a [NCH];
  logic [31:0]    a1_a [NCH];
  logic [31:0]    am1_a [NCH];
  logic [31:0]    desc_a [NCH];
  logic [31:0]    swp_a [NCH];

  dmarb_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .CH_BASE(CH_BASE)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .gsel(gsel), .ch_hit(ch_hit), .ch_idx(ch_idx), .wreg(wreg),
    .wr_ch(wr_ch), .rd_csr(rd_csr_w), .rd_srca(rd_srca_w),
    .gwr(gwr), .rd_null(rd_null_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmarb_channel u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ch[g]), .wr_reg(wreg),
      .wdata(bus_wdata), .rd_csr(rd_csr_w[g]),
      .ev_done(ch_done_i[g]), .ev_err(ch_err_i[g]), .ev_chunk(ch_chunk_i[g]),
      .busy_i(ch_busy_i[g]), .mask_bit(mska[g]),
      .csr(csr_a[g]), .sz(sz_a[g]), .a0(a0_a[g]), .am0(am0_a[g]),
      .a1(a1_a[g]), .am1(am1_a[g]), .desc(desc_a[g]), .swptr(swp_a[g]),
      .start_o(ch_start_o[g]), .cancel_o(ch_cancel_o[g]), .raise_o(raise_w[g])
    );
    assign ch_csr_o[g*DW +: DW]   = csr_a[g];
    assign ch_sz_o[g*DW +: DW]    = sz_a[g];
    assign ch_a0_o[g*DW +: DW]    = a0_a[g];
    assign ch_am0_o[g*DW +: DW]   = am0_a[g];
    assign ch_a1_o[g*DW +: DW]    = a1_a[g];
    assign ch_am1_o[g*DW +: DW]   = am1_a[g];
    assign ch_desc_o[g*DW +: DW]  = desc_a[g];
    assign ch_swptr_o[g*DW +: DW] = swp_a[g];
    assign wr_csr_w[g] = wr_ch[g] && (wreg == W_CSR);
    assign ev_any_w[g] = ch_done_i[g] || ch_err_i[g] || ch_chunk_i[g];
  end

  dmarb_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .raise(raise_w), .gwr(gwr), .gsel(gsel),
    .wdata(bus_wdata), .rd_srca(rd_srca_w),
    .mska(mska), .mskb(mskb), .srca(srca), .srcb(srcb), .irq(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (ch_hit) begin
      case (wreg)
        W_CSR:   rd_mux = csr_a[ch_idx];
        W_SZ:    rd_mux = sz_a[ch_idx];
        W_A0:    rd_mux = a0_a[ch_idx];
        W_AM0:   rd_mux = am0_a[ch_idx];
        W_A1:    rd_mux = a1_a[ch_idx];
        W_AM1:   rd_mux = am1_a[ch_idx];
        W_DESC:  rd_mux = desc_a[ch_idx];
        default: rd_mux = swp_a[ch_idx];
      endcase
    end else begin
      case (gsel)
        G_MSKA:  rd_mux = mska;
        G_MSKB:  rd_mux = mskb;
        G_SRCA:  rd_mux = srca;
        G_SRCB:  rd_mux = srcb;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dmarb_checker.sv
module dmarb_checker
  import dmarb_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [NCH-1:0]    start_s,
  input logic [NCH-1:0]    cancel_s,
  input logic              irq_s,
  input logic [NCH-1:0]    raise_s,
  input logic              rd_srca_s,
  input logic [31:0]       srca_s,
  input logic [NCH-1:0]    rd_csr_s,
  input logic [NCH-1:0]    wr_csr_s,
  input logic [NCH-1:0]    ev_any_s,
  input logic [NCH-1:0]    done_s,
  input logic [NCH*32-1:0] csr_s,
  input logic              rd_null_s
);
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));

  assert_strobe_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(start_s | cancel_s)) |-> $past(bus_valid && bus_write));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_s & cancel_s) == '0);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_s) |-> $past(|raise_s));

  assert_src_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_srca_s && !(|raise_s)) |=> (srca_s == '0) && !irq_s);

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_srca_s && (|raise_s)) |=> irq_s && (srca_s != '0));

  assert_null_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_null_s |=> (bus_rdata == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    assert_csr_wmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_csr_s[i] && !ev_any_s[i]) |=>
        ((csr_s[i*32 +: 32] & CSR_WMASK) == ($past(bus_wdata) & CSR_WMASK)));

    assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_s[i] |=> (csr_s[i*32 + B_DONE] && !csr_s[i*32 + B_EN]));

    assert_csr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_csr_s[i] && !ev_any_s[i]) |=> ((csr_s[i*32 +: 32] & CSR_RCLR) == '0));
  end
endmodule

bind dma_regbank dmarb_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .start_s(ch_start_o), .cancel_s(ch_cancel_o), .irq_s(irq_o),
  .raise_s(raise_w), .rd_srca_s(rd_srca_w), .srca_s(srca),
  .rd_csr_s(rd_csr_w), .wr_csr_s(wr_csr_w), .ev_any_s(ev_any_w),
  .done_s(ch_done_i), .csr_s(ch_csr_o), .rd_null_s(rd_null_w)
);

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;
  localparam int AW = 8;
  localparam int N  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [N*32-1:0] csr_o, sz_o, a0_o, am0_o, a1_o, am1_o, desc_o, swp_o;
  logic [N-1:0]  start_o, cancel_o;
  logic [N-1:0]  done_i = '0, err_i = '0, chunk_i = '0, busy_i = '0;
  logic          irq_o;

  int nchk = 0;
  int nbad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dma_regbank #(.ADDR_W(AW), .NCH(N), .CH_BASE(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_csr_o(csr_o), .ch_sz_o(sz_o), .ch_a0_o(a0_o),
    .ch_am0_o(am0_o), .ch_a1_o(a1_o), .ch_am1_o(am1_o), .ch_desc_o(desc_o),
    .ch_swptr_o(swp_o), .ch_start_o(start_o), .ch_cancel_o(cancel_o),
    .ch_done_i(done_i), .ch_err_i(err_i), .ch_chunk_i(chunk_i),
    .ch_busy_i(busy_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R2 unexpected read data actual=%08h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  task automatic op(input logic v, input logic w, input logic [AW-1:0] a,
                    input logic [31:0] d, input logic [N-1:0] dn, input logic [N-1:0] er);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    done_i = dn; err_i = er;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; done_i = '0; err_i = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    op(1'b1, 1'b1, a, d, '0, '0);
  endtask

  task automatic rd_ev(input logic [AW-1:0] a, input logic [31:0] e, input string t,
                       input logic [N-1:0] dn, input logic [N-1:0] er);
    exp_q.push_back(e);
    tag_q.push_back(t);
    op(1'b1, 1'b0, a, '0, dn, er);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    rd_ev(a, e, t, '0, '0);
  endtask

  task automatic ev(input logic [N-1:0] dn, input logic [N-1:0] er);
    op(1'b0, 1'b0, '0, '0, dn, er);
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nbad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 am0 out", am0_o[31:0], 32'hFFFF_FFFC);
    rd(8'h0C, 32'h0, "R1 srcA");
    rd(8'h04, 32'h0, "R1 maskA");
    rd(8'h2C, 32'hFFFF_FFFC, "R1 ch0 AM0");
    rd(8'h94, 32'hFFFF_FFFC, "R1 ch3 AM1");
    rd(8'h48, 32'h0, "R1 ch1 A0");
    rd(8'h20, 32'h0, "R1 ch0 CSR");

    // R2 window decode and readback
    wr(8'h50, 32'h1234_5678);
    wr(8'h30, 32'hCAFE_0000);
    rd(8'h50, 32'h1234_5678, "R2 ch1 A1");
    rd(8'h30, 32'hCAFE_0000, "R2 ch0 A1");
    chk("R2 ch1 A1 out", a1_o[63:32], 32'h1234_5678);
    wr(8'h84, 32'h0001_0008);
    wr(8'h98, 32'h0000_4000);
    wr(8'h9C, 32'h0000_0044);
    rd(8'h84, 32'h0001_0008, "R2 ch3 SZ");
    rd(8'h98, 32'h0000_4000, "R2 ch3 DESC");
    rd(8'h9C, 32'h0000_0044, "R2 ch3 SWPTR");
    chk("R2 ch3 desc out", desc_o[127:96], 32'h0000_4000);

    // R3 / R4 write mask and strobes
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R4 start on 0->1", {28'd0, start_o}, 32'h1);
    chk("R4 no cancel", {28'd0, cancel_o}, 32'h0);
    rd(8'h20, 32'h0000_1FF1, "R3 masked CSR");
    wr(8'h20, 32'h0000_0801);
    chk("R4 no start when EN already 1", {28'd0, start_o}, 32'h0);
    wr(8'h04, 32'h3);

    // R5 / R6 / R9 / R8 done interrupt path
    ev(4'b0001, 4'b0000);
    chk("R6 irq high", {31'd0, irq_o}, 32'd1);
    rd(8'h20, 32'h0000_4804, "R5 R6 CSR after done");
    rd(8'h20, 32'h0000_0804, "R9 sticky cleared");
    chk("R9 irq untouched", {31'd0, irq_o}, 32'd1);
    rd(8'h0C, 32'h1, "R6 srcA onehot");
    chk("R8 irq drops", {31'd0, irq_o}, 32'd0);
    rd(8'h0C, 32'h0, "R8 srcA cleared");

    // R4 cancel and start on channel 1
    wr(8'h40, 32'h0);
    chk("R4 cancel", {28'd0, cancel_o}, 32'h2);
    chk("R4 no start on cancel", {28'd0, start_o}, 32'h0);
    wr(8'h40, 32'h0000_0401);
    chk("R4 start ch1", {28'd0, start_o}, 32'h2);

    // R7 masked event
    wr(8'h04, 32'h1);
    ev(4'b0000, 4'b0010);
    chk("R7 irq stays low", {31'd0, irq_o}, 32'd0);
    rd(8'h0C, 32'h0, "R7 srcA untouched");
    rd(8'h40, 32'h0000_0408, "R5 R7 CSR err no INT");
    rd(8'h40, 32'h0000_0400, "R9 ERR cleared");

    // R10 source A read collides with new interrupt
    wr(8'h20, 32'h0000_0801);
    chk("R4 restart ch0", {28'd0, start_o}, 32'h1);
    wr(8'h04, 32'h3);
    ev(4'b0001, 4'b0000);
    wr(8'h40, 32'h0000_0401);
    rd_ev(8'h0C, 32'h1, "R10 srcA read old value", 4'b0000, 4'b0010);
    chk("R10 irq survives", {31'd0, irq_o}, 32'd1);
    rd(8'h0C, 32'h2, "R10 srcA new value");
    chk("R8 irq drops again", {31'd0, irq_o}, 32'd0);

    // R10 CSR read collides with error event
    rd_ev(8'h40, 32'h0000_2408, "R10 CSR read old", 4'b0000, 4'b0010);
    rd(8'h40, 32'h0000_2408, "R10 sticky survives");
    rd(8'h40, 32'h0000_0400, "R9 cleared after");
    rd(8'h0C, 32'h2, "R10 srcA after CSR clash");

    // R6 two channels in one cycle
    rd(8'h20, 32'h0000_4804, "R9 ch0 pre-clear");
    wr(8'h20, 32'h0000_0801);
    wr(8'h40, 32'h0000_0801);
    ev(4'b0011, 4'b0000);
    rd(8'h0C, 32'h1, "R6 lowest index wins");
    rd(8'h40, 32'h0000_4804, "R6 ch1 INT_DONE set");

    // R11 global area
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R11 global CSR reads zero");
    wr(8'h14, 32'h55);
    rd(8'h14, 32'h0, "R11 undefined offset");
    rd(8'h04, 32'h3, "R11 maskA kept");
    wr(8'h08, 32'h0000_A5A5);
    rd(8'h08, 32'h0000_A5A5, "R11 maskB");
    wr(8'h10, 32'h77);
    rd(8'h10, 32'h77, "R11 srcB");

    // R12 out-of-range channel window
    wr(8'hA8, 32'h0000_DEAD);
    rd(8'hA8, 32'h0, "R12 out of range read");
    rd(8'hE0, 32'h0, "R12 high address");
    rd(8'h88, 32'h0, "R12 ch3 A0 untouched");
    rd(8'h28, 32'h0, "R12 ch0 A0 untouched");

    // R5 / R3 busy mirror not writable
    busy_i = 4'b0100;
    rd(8'h60, 32'h0000_0002, "R5 busy mirrored");
    wr(8'h60, 32'h0);
    rd(8'h60, 32'h0000_0002, "R3 busy not writable");
    busy_i = '0;

    repeat (4) @(negedge clk);
    chk("R2 all reads answered", exp_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule